// File: doc/BRIEF.md
# Multi-Channel Interval Timer

This block is a four-channel down-counting timer peripheral reached through a plain register bus: a byte address, a write strobe, write data and combinational read data. Software writes a 31-bit interval into a channel. The channel then counts down by one on every clock. When the count runs out, the channel raises its pending flag. In repeat mode it then reloads the stored interval. In one-shot mode it stops.

The top bit of an interval write selects when the new value takes effect. When the bit is set, the counter loads the value at once. When the bit is clear, the value waits in the interval register until the current count expires. Each channel has an interrupt enable. The enabled pending flags are ORed into a single interrupt line.

Two shared registers serve the interrupt handler and the channel allocator. One returns all pending flags as a bit vector and clears any set of them in one write. The other returns the number of the lowest-numbered channel that is not running. Software uses that number to claim a free channel without scanning the channels one by one.

Top module: `mc_interval_timer`

## Requirements
- R1: After reset every interval, count, control and status value reads 0, the idle register reads 0x00 and `irq_out` is 0.
- R2: An interval write with bit 31 = 1 and value V (bits 30:0) makes the count read V from the next cycle, and the running bit equal 1 exactly when V is nonzero. The count then falls by one per clock.
- R3: An interval write with bit 31 = 0 to a running channel leaves the count alone. The interval register reads the new value, which is loaded at the next expiry. The same write to an idle channel loads and starts at once.
- R4: In one-shot mode (control bits 2:1 = 1), the clock edge at which the count is 1 leaves the count at 0, the running bit at 0 and the pending flag at 1.
- R5: In repeat mode (control bits 2:1 = 0), the clock edge at which the count is 1 reloads the stored interval and sets the pending flag, so an interval N expires every N clocks.
- R6: An immediate load of zero stops the channel with count 0 and leaves the pending flag as it was.
- R7: Writing a status word with bit 0 = 1 clears that channel's pending flag, and writing bit 0 = 0 has no effect. Writing 1 to bit n of the global flag register clears channel n's flag.
- R8: If a flag clear and an expiry fall on the same clock edge of one channel, the flag ends up set.
- R9: `irq_out` is 1 exactly when some channel has both its pending flag and its enable (control bit 0) set. The flag is set on expiry even when the enable is 0.
- R10: The idle register at 0xF4 holds, in bits 7:4, the lowest channel number whose running bit is 0, and reads 0x40 when all four channels run.
- R11: Channel n occupies bytes 16n to 16n+15, with the interval at offset 0, the count at 4, control at 8 and status at 0xC. The global flag register is at 0xF8. Control reads {mode, enable} in bits 2:0, and any mode value other than 1 is stored and read back as 0. Status reads {running, flag} in bits 1:0. The interval reads with bit 31 = 0. Writes to the count register are ignored, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, acts on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | OR of enabled pending flags |

## Verification
The bench lands a status clear on the same edge as a repeat expiry. A design that gives the clear priority would lose that interrupt. It sends a deferred interval write one cycle before an expiry and checks that the new value, not the old one, is reloaded. It also checks that the same write to an idle channel starts it at once, because a design that always defers would leave such a channel stuck. It drives the idle register through partial and full occupancy and back. A wrong search order would show there as a higher channel number, and a missing no-idle code would show as a value other than 0x40. It also checks that a zero load keeps an old flag, that mode value 3 reads back as repeat and that a write to the count register is ignored.

// File: rtl/tmr_pkg.sv
// Shared constants of the interval timer: register offsets inside a
// channel block, shared register addresses and the mode encoding.
// Assumes a byte-addressed bus with 32-bit aligned registers.
package tmr_pkg;
    localparam int DW        = 32;
    localparam int AW        = 8;
    localparam logic [1:0] RS_IVAL = 2'd0;
    localparam logic [1:0] RS_CNT  = 2'd1;
    localparam logic [1:0] RS_CTRL = 2'd2;
    localparam logic [1:0] RS_STAT = 2'd3;
    localparam logic [AW-1:0] IDLE_ADDR = 8'hF4;
    localparam logic [AW-1:0] FLAG_ADDR = 8'hF8;

    typedef enum logic [1:0] {
        MODE_REPEAT  = 2'd0,
        MODE_ONESHOT = 2'd1
    } tmr_mode_e;
endpackage

// File: rtl/tmr_channel.sv
// One timer channel: stored interval, down-counter, mode, enable and
// pending flag. Assumes the top decodes addresses and hands in one-cycle
// write strobes. An immediate interval write takes priority over an
// expiry on the same edge; a flag set by expiry beats any clear.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int IVW = 31
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_ival,
    input  logic           wr_ctrl,
    input  logic           wr_stat,
    input  logic           gclr,
    input  logic [DW-1:0]  wdata,
    output logic [IVW-1:0] cnt,
    output logic [IVW-1:0] ival,
    output logic           ie,
    output logic           oneshot,
    output logic           pend,
    output logic           run
);
    logic           imm;
    logic [IVW-1:0] wval;
    logic           expire;
    logic           flag_clr;
    logic           load_now;
    logic [IVW-1:0] next_ival;
    logic           unused_wbits;

    assign imm          = wdata[DW-1];
    assign wval         = wdata[IVW-1:0];
    assign expire       = run && (cnt == IVW'(1));
    assign load_now     = wr_ival && (imm || !run);
    assign next_ival    = wr_ival ? wval : ival;
    assign flag_clr     = (wr_stat && wdata[0]) || gclr;
    assign unused_wbits = ^wdata;

    // Keep the reload value; any interval write replaces it.
    always_ff @(posedge clk) begin
        if (!rst_n)       ival <= '0;
        else if (wr_ival) ival <= wval;
    end

    // Hold the enable and the mode; mode codes other than one-shot map to repeat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie      <= 1'b0;
            oneshot <= 1'b0;
        end else if (wr_ctrl) begin
            ie      <= wdata[0];
            oneshot <= (wdata[2:1] == MODE_ONESHOT);
        end
    end

    // Count down, reload or stop, and track the running state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (load_now) begin
            cnt <= wval;
            run <= (wval != '0);
        end else if (expire) begin
            if (oneshot || next_ival == '0) begin
                cnt <= '0;
                run <= 1'b0;
            end else begin
                cnt <= next_ival;
            end
        end else if (run) begin
            cnt <= cnt - IVW'(1);
        end
    end

    // Set the pending flag on expiry, else clear it on request.
    always_ff @(posedge clk) begin
        if (!rst_n)                                pend <= 1'b0;
        else if (expire && !(wr_ival && imm))      pend <= 1'b1;
        else if (flag_clr)                         pend <= 1'b0;
    end

    // R2: an immediate load shows up in the count and running bit
    a_r2_imm_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ival && imm) |=> (cnt == $past(wval)) && (run == ($past(wval) != '0)));

    // R4: one-shot expiry stops the channel with the flag raised
    a_r4_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && oneshot && !wr_ival) |=> (!run && cnt == '0 && pend));

    // R5: repeat expiry reloads the stored interval
    a_r5_repeat_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !oneshot && !wr_ival && ival != '0) |=> (run && cnt == $past(ival)));

    // R7: a clear without an expiry drops the flag
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && flag_clr && !expire) |=> !pend);

    // R8: an expiry always leaves the flag set, even against a clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !(wr_ival && imm)) |=> pend);
endmodule

// File: rtl/tmr_idle_find.sv
// Priority search for the lowest-numbered channel that is not running.
// Returns NCH when every channel runs. Pure combinational logic.
module tmr_idle_find #(
    parameter int NCH = 4,
    localparam int IW = $clog2(NCH + 1)
) (
    input  logic [NCH-1:0] running,
    output logic [IW-1:0]  idx
);
    // Scan from the top down so the lowest idle channel is written last.
    always_comb begin
        idx = IW'(NCH);
        for (int i = NCH - 1; i >= 0; i--) begin
            if (!running[i]) idx = IW'(i);
        end
    end

    // R10: a reported channel is really idle, and lower ones all run
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            if (idx == IW'(i)) a_r10_idle_ok: assert (!running[i]);
            if (idx > IW'(i))  a_r10_lower_busy: assert (running[i]);
        end
    end
endmodule

// File: rtl/mc_interval_timer.sv
// Top of the multi-channel interval timer. Decodes the register bus,
// instantiates one channel per timer, builds the idle and global flag
// registers and the combined interrupt. Assumes single-cycle writes and
// a combinational read path; NCH must stay below 16 so the idle number
// fits its 4-bit field and the channel blocks fit below 0xF4.
module mc_interval_timer
    import tmr_pkg::*;
#(
    parameter int NCH = 4,
    parameter int IVW = 31,
    localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int IW   = $clog2(NCH + 1),
    localparam int SPAN = NCH * 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_out
);
    logic [IVW-1:0] ch_cnt  [NCH];
    logic [IVW-1:0] ch_ival [NCH];
    logic [NCH-1:0] ch_ie, ch_os, ch_pend, ch_run;
    logic [NCH-1:0] gclr_vec;
    logic [IW-1:0]  idle_idx;
    logic           in_chan;
    logic [CHW-1:0] rd_ch;
    logic [1:0]     rsel;
    logic           unused_addr;

    assign in_chan     = (bus_addr < AW'(SPAN));
    assign rd_ch       = bus_addr[CHW+3:4];
    assign rsel        = bus_addr[3:2];
    assign gclr_vec    = (bus_we && bus_addr == FLAG_ADDR) ? bus_wdata[NCH-1:0] : '0;
    assign unused_addr = ^bus_addr[1:0];

    // One channel per timer, each with its own write strobes.
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit;
        assign hit = bus_we && in_chan && (bus_addr[AW-1:4] == (AW-4)'(i));
        tmr_channel #(.IVW(IVW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_ival (hit && rsel == RS_IVAL),
            .wr_ctrl (hit && rsel == RS_CTRL),
            .wr_stat (hit && rsel == RS_STAT),
            .gclr    (gclr_vec[i]),
            .wdata   (bus_wdata),
            .cnt     (ch_cnt[i]),
            .ival    (ch_ival[i]),
            .ie      (ch_ie[i]),
            .oneshot (ch_os[i]),
            .pend    (ch_pend[i]),
            .run     (ch_run[i])
        );
    end

    tmr_idle_find #(.NCH(NCH)) u_idle (
        .running (ch_run),
        .idx     (idle_idx)
    );

    assign irq_out = |(ch_pend & ch_ie);

    // Select read data for the addressed register.
    always_comb begin
        bus_rdata = '0;
        if (in_chan) begin
            case (rsel)
                RS_IVAL: bus_rdata = DW'(ch_ival[rd_ch]);
                RS_CNT:  bus_rdata = DW'(ch_cnt[rd_ch]);
                RS_CTRL: bus_rdata = DW'({1'b0, ch_os[rd_ch], ch_ie[rd_ch]});
                default: bus_rdata = DW'({ch_run[rd_ch], ch_pend[rd_ch]});
            endcase
        end else if (bus_addr == IDLE_ADDR) begin
            bus_rdata = DW'(idle_idx) << 4;
        end else if (bus_addr == FLAG_ADDR) begin
            bus_rdata = DW'(ch_pend);
        end
    end

    // R9: the interrupt line needs a pending flag behind it
    a_r9_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (|ch_pend));
endmodule

// File: tb/mc_interval_timer_bench.sv
`timescale 1ns/100ps
module mc_interval_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];
    event  smp;

    always #5 clk = ~clk;

    mc_interval_timer u_mc_interval_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    // Monitor: pops the expected item and compares the sampled output.
    initial begin
        item_t it;
        logic [31:0] act;
        forever begin
            @smp;
            #0.1;
            it = sb.pop_front();
            act = it.is_irq ? {31'b0, irq_out} : bus_rdata;
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s actual=0x%08h expected=0x%08h", it.tag, act, it.exp);
            end
        end
    end

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb.push_back(it);
        bus_addr = a;
        -> smp;
        #0.2;
    endtask

    task automatic irq_chk(input logic e, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
        sb.push_back(it);
        -> smp;
        #0.2;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        #0.1;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #0.1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        #0.1;
        // R1 reset state
        rd_chk(8'h04, 32'h0, "R1 ch0 count");
        rd_chk(8'h0C, 32'h0, "R1 ch0 status");
        rd_chk(8'hF4, 32'h0, "R1 idle");
        rd_chk(8'hF8, 32'h0, "R1 flags");
        irq_chk(1'b0, "R1 irq");

        // R2 immediate load then decrement
        wr(8'h00, 32'h8000_0005);
        rd_chk(8'h04, 32'd5, "R2 count after load");
        rd_chk(8'h0C, 32'h2, "R2 running");
        tick(1);
        rd_chk(8'h04, 32'd4, "R2 decrement");
        tick(2);
        rd_chk(8'h04, 32'd2, "R2 decrement x3");
        tick(2);
        // R5 repeat reload and flag; R9 flag without enable
        rd_chk(8'h04, 32'd5, "R5 reload");
        rd_chk(8'h0C, 32'h3, "R5 flag set");
        rd_chk(8'hF8, 32'h1, "R11 global flags");
        irq_chk(1'b0, "R9 flag but disabled");
        wr(8'h08, 32'h1);
        irq_chk(1'b1, "R9 enabled irq");
        rd_chk(8'h08, 32'h1, "R11 ctrl readback");
        // R7 clear rules
        wr(8'h0C, 32'h0);
        rd_chk(8'h0C, 32'h3, "R7 write zero no effect");
        wr(8'h0C, 32'h1);
        rd_chk(8'h0C, 32'h2, "R7 status clear");
        irq_chk(1'b0, "R9 irq after clear");
        // R3 deferred load on running channel
        wr(8'h00, 32'h0000_0003);
        rd_chk(8'h04, 32'd1, "R3 count untouched");
        rd_chk(8'h00, 32'd3, "R3 interval stored");
        tick(1);
        rd_chk(8'h04, 32'd3, "R3 new value at expiry");
        rd_chk(8'h0C, 32'h3, "R3 expiry flag");
        tick(2);
        // R8 clear on the expiry edge
        wr(8'h0C, 32'h1);
        rd_chk(8'h0C, 32'h3, "R8 set wins");
        rd_chk(8'h04, 32'd3, "R8 reload");
        wr(8'hF8, 32'h1);
        rd_chk(8'h0C, 32'h2, "R7 global clear");

        // R4 one-shot on channel 1
        wr(8'h18, 32'h2);
        wr(8'h10, 32'h8000_0002);
        rd_chk(8'h18, 32'h2, "R11 oneshot mode readback");
        rd_chk(8'h14, 32'd2, "R4 loaded");
        tick(2);
        rd_chk(8'h14, 32'd0, "R4 count zero");
        rd_chk(8'h1C, 32'h1, "R4 stopped with flag");
        rd_chk(8'hF4, 32'h10, "R10 lowest idle is 1");

        // R11 mode encoding on channel 2
        wr(8'h28, 32'h7);
        rd_chk(8'h28, 32'h1, "R11 mode 3 maps to repeat");
        wr(8'h28, 32'h6);
        rd_chk(8'h28, 32'h0, "R11 mode 3 no enable");

        // R10 all busy
        wr(8'h10, 32'h8000_1000);
        wr(8'h20, 32'h8000_1000);
        wr(8'h30, 32'h8000_1000);
        rd_chk(8'hF4, 32'h40, "R10 none idle");
        rd_chk(8'h30, 32'h1000, "R11 interval bit31 reads 0");
        // R6 zero load
        wr(8'h20, 32'h8000_0000);
        rd_chk(8'h24, 32'h0, "R6 count zero");
        rd_chk(8'h2C, 32'h0, "R6 stopped");
        rd_chk(8'hF4, 32'h20, "R10 lowest idle is 2");
        wr(8'h10, 32'h8000_0000);
        rd_chk(8'h1C, 32'h1, "R6 flag kept");
        rd_chk(8'hF4, 32'h10, "R10 lowest idle back to 1");
        wr(8'h00, 32'h8000_0000);
        wr(8'h18, 32'h1);
        irq_chk(1'b1, "R9 irq from ch1");
        wr(8'hF8, 32'h3);
        rd_chk(8'hF8, 32'h0, "R7 multi clear");
        irq_chk(1'b0, "R9 irq low after multi clear");

        // R11 ignored count write and unmapped read
        wr(8'h24, 32'h8000_0009);
        rd_chk(8'h24, 32'h0, "R11 count write ignored");
        rd_chk(8'h2C, 32'h0, "R11 status unchanged");
        rd_chk(8'hF0, 32'h0, "R11 unmapped read");
        // R3 deferred write into idle channel starts it
        wr(8'h20, 32'h0000_0007);
        rd_chk(8'h24, 32'd7, "R3 idle loads at once");
        rd_chk(8'h2C, 32'h2, "R3 idle starts");

        #1;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule